// File: doc/BRIEF.md
# Serial Frame Sequence Checker

This block is a synthesizable checker that sits beside an asynchronous serial
transmitter and watches it from the outside. It sees the write handshake, the
busy flag, the serial line and a strobe that marks the last clock of each bit
interval. It does not count cycles or bit positions. It tracks where the frame
should be with one one-hot position vector for each data length (5, 6, 7 and 8
bits). All of these vectors feed one shared three-position vector for the
parity and stop bits. A final one-clock "gap" slot follows the last stop bit.

When a write is accepted, the checker captures the byte and the line
configuration. From then on it compares every clock of every bit interval with
the value the line must carry. It also checks the busy flag against the frame
position. The first mismatch sets a sticky error flag and stores a code that
names the failed check. A one-clock done pulse marks each frame that ran to its
end. A break input drops whatever frame is being followed. The error state
survives a break.

The control state machine has four states:
- `PH_IDLE`: no frame is being followed.
- `PH_DATA`: a length vector is active (start bit or data bits).
- `PH_TAIL`: the parity/stop vector is active.
- `PH_GAP`: the single clock after the final stop bit.

Its transitions are:
- IDLE→DATA on an accepted write.
- DATA→TAIL when a strobe ends the last data bit.
- TAIL→GAP when a strobe ends the final stop bit.
- GAP→DATA on an accepted write, otherwise GAP→IDLE.
- Any state→IDLE on reset or break.

Top module: `uart_frame_monitor`

## Requirements
- R1: A write is accepted only in a clock where `wr_stb`=1, `busy`=0 and the checker is idle or in its gap clock. On acceptance the byte and the configuration (`cfg_len`, `cfg_par_en`, `cfg_par_fix`, `cfg_par_sel`, `cfg_two_stop`) are captured, and the start position is active from the next clock. A write while `busy`=1 starts nothing: no later check runs and no done pulse appears. Configuration inputs that change after acceptance have no effect on the frame.
- R2: Frame positions advance only at the end of a clock in which `baud_end`=1. Each position spans any number of clocks, one or more, and `baud_end` pulses while idle are ignored.
- R3: In the start position `tx` must be 0, otherwise code 1. In data position k (k=1..N) `tx` must equal captured bit k-1, sent least significant bit first, otherwise code 2.
- R4: `cfg_len` picks the data length as 0→5, 1→6, 2→7, 3→8 bits. Only the vector for that length is loaded, and at most one length vector is ever nonzero.
- R5: After the last data bit the frame enters the parity position if parity is enabled. Otherwise it enters the first of two stop positions if `cfg_two_stop`=1. Otherwise it enters the final stop position. After parity the same two-stop choice is made. After the first of two stops comes the final stop.
- R6: In the parity position `tx` must match the parity value, otherwise code 3. With `cfg_par_fix`=0 the value is the XOR of the N data bits for `cfg_par_sel`=0 (even) and its inverse for `cfg_par_sel`=1 (odd). With `cfg_par_fix`=1 the value is `cfg_par_sel` itself (1 mark, 0 space).
- R7: In each stop position `tx` must be 1, otherwise code 4.
- R8: `busy` must be 1 in every clock where a frame position is active, otherwise code 5. In the gap clock after the final stop `busy` must be 0, otherwise code 6.
- R9: Every position vector is one-hot or all zero.
- R10: Reset clears `err_flag` and `err_code` to 0. The first clock with a failed check sets `err_flag`, one clock later, and stores the lowest failing code of that clock. Both then hold until reset.
- R11: `frame_done` is 1 for exactly the one clock that follows the `baud_end` clock ending the final stop position.
- R12: A clock with `brk`=1 runs no check. It clears every position vector and the gap slot at once, so the frame in progress gives no later error and no done pulse. The error state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk | input | 1 | Break: abandon the followed frame |
| wr_stb | input | 1 | Transmitter write request |
| wr_data | input | DATA_W | Byte offered with the write |
| busy | input | 1 | Transmitter busy flag |
| tx | input | 1 | Serial line |
| baud_end | input | 1 | High on the last clock of a bit interval |
| cfg_len | input | LEN_W | Data length select (0→5 … 3→8) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_fix | input | 1 | Fixed parity value instead of computed |
| cfg_par_sel | input | 1 | Odd/even select, or the fixed value |
| cfg_two_stop | input | 1 | Two stop bits |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 3 | Code of the first failed check |
| frame_done | output | 1 | One-clock pulse after a completed frame |

## Verification
Clean frames are run at every data length and with all four parity kinds. They
are also run with one and two stop bits and with bit intervals of one, two,
three and six clocks. This separates the length and tail routing from the timing
of the strobe. Frames chained through the gap clock show that a write is
accepted exactly there. A write against a high busy flag, followed by a line
that would fail a start check, shows that such a write is not tracked. Single
faults are placed on the start, data, parity and stop bits, on busy inside the
frame and on busy in the gap. Each fault must yield its own code. Combined and
repeated faults expose the priority and the sticky hold. A break in mid-frame
must remove both the later errors and the done pulse.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

    localparam int ERR_W      = 3;
    localparam int NUM_CHECKS = 6;

    // Check numbers; the number is also the reported error code.
    localparam int EC_START     = 1;
    localparam int EC_DATA      = 2;
    localparam int EC_PARITY    = 3;
    localparam int EC_STOP      = 4;
    localparam int EC_BUSY_LOW  = 5;
    localparam int EC_BUSY_HIGH = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2,
        PH_GAP  = 2'd3
    } mon_phase_e;

    typedef struct packed {
        logic par_en;
        logic par_fix;
        logic par_sel;
        logic two_stop;
    } line_cfg_t;

endpackage

// File: rtl/uart_mon_len_track.sv
module uart_mon_len_track #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic [NBITS-1:0] data,
    output logic             active,
    output logic             at_start,
    output logic             at_data,
    output logic             exp_bit,
    output logic             last_exit
);

    // pos[0] = start bit, pos[k] = data bit k-1
    logic [NBITS:0] pos;

    always_ff @(posedge clk) begin
        if (clr)
            pos <= '0;
        else if (load)
            pos <= {{NBITS{1'b0}}, 1'b1};
        else if (step)
            pos <= {pos[NBITS-1:0], 1'b0};
    end

    assign active    = |pos;
    assign at_start  = pos[0];
    assign at_data   = |pos[NBITS:1];
    assign exp_bit   = |(pos[NBITS:1] & data);
    assign last_exit = step & pos[NBITS];

    assert_onehot_pos_R9: assert property (@(posedge clk) disable iff (clr)
        $onehot0(pos));

    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (clr)
        (!step && !load) |=> $stable(pos));

endmodule

// File: rtl/uart_mon_tail_track.sv
module uart_mon_tail_track (
    input  logic clk,
    input  logic clr,
    input  logic enter,
    input  logic step,
    input  logic par_en,
    input  logic two_stop,
    output logic in_par,
    output logic in_stop1,
    output logic in_stopf,
    output logic in_gap,
    output logic active
);

    localparam int TP_PAR   = 0;
    localparam int TP_STOP1 = 1;
    localparam int TP_STOPF = 2;

    logic [2:0] tail, nxt;
    logic       gap;

    always_comb begin
        nxt = '0;
        if (tail[TP_PAR]) begin
            if (two_stop) nxt[TP_STOP1] = 1'b1;
            else          nxt[TP_STOPF] = 1'b1;
        end
        if (tail[TP_STOP1])
            nxt[TP_STOPF] = 1'b1;
        if (enter) begin
            if (par_en)        nxt[TP_PAR]   = 1'b1;
            else if (two_stop) nxt[TP_STOP1] = 1'b1;
            else               nxt[TP_STOPF] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            tail <= '0;
            gap  <= 1'b0;
        end else begin
            gap <= step & tail[TP_STOPF];
            if (step)
                tail <= nxt;
        end
    end

    assign in_par   = tail[TP_PAR];
    assign in_stop1 = tail[TP_STOP1];
    assign in_stopf = tail[TP_STOPF];
    assign in_gap   = gap;
    assign active   = |tail;

    assert_onehot_tail_R9: assert property (@(posedge clk) disable iff (clr)
        $onehot0(tail));

    assert_gap_one_clock_R11: assert property (@(posedge clk) disable iff (clr)
        gap |=> !gap);

    assert_after_parity_R5: assert property (@(posedge clk) disable iff (clr)
        (tail[TP_PAR] && step) |=> (tail[TP_STOP1] || tail[TP_STOPF]));

endmodule

// File: rtl/uart_mon_err.sv
module uart_mon_err
    import uart_mon_pkg::*;
#(
    parameter int NCHK = NUM_CHECKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCHK:1]    hit,
    output logic             flag,
    output logic [ERR_W-1:0] code
);

    logic [ERR_W-1:0] first;

    // lowest numbered failing check wins
    always_comb begin
        first = '0;
        for (int i = NCHK; i >= 1; i--)
            if (hit[i]) first = ERR_W'(i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            code <= '0;
        end else if (!flag && (|hit)) begin
            flag <= 1'b1;
            code <= first;
        end
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        flag |=> (flag && $stable(code)));

    assert_first_hit_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (!flag && (|hit)) |=> (flag && code != '0));

endmodule

// File: rtl/uart_frame_monitor.sv
module uart_frame_monitor
    import uart_mon_pkg::*;
#(
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int DATA_W  = MIN_LEN + (1 << LEN_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              tx,
    input  logic              baud_end,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_fix,
    input  logic              cfg_par_sel,
    input  logic              cfg_two_stop,
    output logic              err_flag,
    output logic [ERR_W-1:0]  err_code,
    output logic              frame_done
);

    localparam int NUM_LEN = 1 << LEN_W;

    mon_phase_e          phase, phase_nxt;
    logic                clr, acc;
    logic [DATA_W-1:0]   masked, cap_data;
    line_cfg_t           cap_cfg;
    logic [NUM_LEN-1:0]  len_act, len_start, len_data, len_exp, len_exit;
    logic                in_par, in_stop1, in_stopf, in_gap, tail_act;
    logic                par_bit, frame_pos, chk_on;
    logic [NUM_CHECKS:1] hit;

    assign clr = rst | brk;
    assign acc = wr_stb & ~busy & ((phase == PH_IDLE) | (phase == PH_GAP));

    // keep only the bits that belong to the selected length
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            masked[i] = wr_data[i] & (i < MIN_LEN + int'(cfg_len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data <= '0;
            cap_cfg  <= '0;
        end else if (acc) begin
            cap_data <= masked;
            cap_cfg  <= '{par_en: cfg_par_en, par_fix: cfg_par_fix,
                          par_sel: cfg_par_sel, two_stop: cfg_two_stop};
        end
    end

    for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
        localparam int NB = MIN_LEN + g;
        uart_mon_len_track #(.NBITS(NB)) u_track (
            .clk       (clk),
            .clr       (clr),
            .load      (acc && (cfg_len == LEN_W'(g))),
            .step      (baud_end),
            .data      (cap_data[NB-1:0]),
            .active    (len_act[g]),
            .at_start  (len_start[g]),
            .at_data   (len_data[g]),
            .exp_bit   (len_exp[g]),
            .last_exit (len_exit[g])
        );
    end

    uart_mon_tail_track u_tail (
        .clk      (clk),
        .clr      (clr),
        .enter    (|len_exit),
        .step     (baud_end),
        .par_en   (cap_cfg.par_en),
        .two_stop (cap_cfg.two_stop),
        .in_par   (in_par),
        .in_stop1 (in_stop1),
        .in_stopf (in_stopf),
        .in_gap   (in_gap),
        .active   (tail_act)
    );

    // state register
    always_ff @(posedge clk) begin
        if (clr) phase <= PH_IDLE;
        else     phase <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: if (acc)                    phase_nxt = PH_DATA;
            PH_DATA: if (|len_exit)              phase_nxt = PH_TAIL;
            PH_TAIL: if (baud_end && in_stopf)   phase_nxt = PH_GAP;
            PH_GAP:  phase_nxt = acc ? PH_DATA : PH_IDLE;
        endcase
    end

    // check outputs
    always_comb begin
        par_bit   = cap_cfg.par_fix ? cap_cfg.par_sel : ((^cap_data) ^ cap_cfg.par_sel);
        frame_pos = (|len_act) | tail_act;
        chk_on    = ~brk;
        hit = '0;
        hit[EC_START]     = chk_on & (|len_start) & tx;
        hit[EC_DATA]      = chk_on & (|len_data) & (tx != (|len_exp));
        hit[EC_PARITY]    = chk_on & in_par & (tx != par_bit);
        hit[EC_STOP]      = chk_on & (in_stop1 | in_stopf) & ~tx;
        hit[EC_BUSY_LOW]  = chk_on & frame_pos & ~busy;
        hit[EC_BUSY_HIGH] = chk_on & in_gap & busy;
    end

    uart_mon_err #(.NCHK(NUM_CHECKS)) u_err (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .flag (err_flag),
        .code (err_code)
    );

    assign frame_done = in_gap;

    assert_len_exclusive_R4: assert property (@(posedge clk) disable iff (clr)
        ($countones(len_act) <= 1) && !((|len_act) && tail_act));

    assert_phase_data_R4: assert property (@(posedge clk) disable iff (clr)
        (phase == PH_DATA) == (|len_act));

    assert_phase_tail_R5: assert property (@(posedge clk) disable iff (clr)
        (phase == PH_TAIL) == tail_act);

    assert_phase_gap_R11: assert property (@(posedge clk) disable iff (clr)
        (phase == PH_GAP) == frame_done);

    assert_accept_loads_R1: assert property (@(posedge clk) disable iff (clr)
        acc |=> ((|len_start) && $countones(len_act) == 1));

endmodule

// File: tb/test_uart_frame_monitor.sv
module test_uart_frame_monitor;

    logic       clk = 1'b0;
    logic       rst, brk, wr_stb, busy, tx, baud_end;
    logic [7:0] wr_data;
    logic [1:0] cfg_len;
    logic       cfg_par_en, cfg_par_fix, cfg_par_sel, cfg_two_stop;
    logic       err_flag, frame_done;
    logic [2:0] err_code;

    int    checks = 0, bad = 0, done_cnt = 0;
    bit    finished = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    uart_frame_monitor i_uart_frame_monitor (
        .clk(clk), .rst(rst), .brk(brk), .wr_stb(wr_stb), .wr_data(wr_data),
        .busy(busy), .tx(tx), .baud_end(baud_end), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_fix(cfg_par_fix),
        .cfg_par_sel(cfg_par_sel), .cfg_two_stop(cfg_two_stop),
        .err_flag(err_flag), .err_code(err_code), .frame_done(frame_done)
    );

    function automatic bit par_of(logic [7:0] m, bit pf, bit ps);
        return pf ? ps : ((^m) ^ ps);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference model: queue of expected intervals ----------
    int q[$];          // entry = expected bit + 2*check code
    bit m_gap = 0, m_err = 0;
    int m_code = 0;

    always @(posedge clk) begin
        int hitc;
        bit was_empty;
        logic [7:0] m;
        int ln;
        if (rst) begin
            q.delete(); m_gap = 0; m_err = 0; m_code = 0;
        end else begin
            hitc = 0;
            if (!brk) begin
                if (q.size() > 0) begin
                    if (int'(tx) != (q[0] & 1)) hitc = q[0] >> 1;
                    else if (!busy) hitc = 5;
                end else if (m_gap && busy) hitc = 6;
            end
            if (!m_err && hitc != 0) begin m_err = 1; m_code = hitc; end
            was_empty = (q.size() == 0);
            m_gap = 0;
            if (brk) q.delete();
            else begin
                if (!was_empty && baud_end) begin
                    void'(q.pop_front());
                    if (q.size() == 0) m_gap = 1;
                end
                if (was_empty && wr_stb && !busy) begin
                    ln = 5 + int'(cfg_len);
                    m = wr_data & 8'((1 << ln) - 1);
                    q.push_back(0 + 2*1);
                    for (int i = 0; i < ln; i++) q.push_back(int'(m[i]) + 2*2);
                    if (cfg_par_en) q.push_back(int'(par_of(m, cfg_par_fix, cfg_par_sel)) + 2*3);
                    if (cfg_two_stop) q.push_back(1 + 2*4);
                    q.push_back(1 + 2*4);
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check({cur_req, " err_flag"}, int'(err_flag), int'(m_err));
            check({cur_req, " err_code"}, int'(err_code), m_code);
            check({cur_req, " frame_done"}, int'(frame_done), int'(m_gap));
            if (frame_done) done_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_stb = 0; busy = 0; tx = 1; brk = 0; baud_end = ~baud_end;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_stb = 0; busy = 0; tx = 1; brk = 0; baud_end = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic send(input logic [7:0] d, input int len, input bit pe, input bit pf,
                        input bit ps, input bit ts, input int cpb, input int flip_at,
                        input int busy_drop_at, input bit gap_busy, input bit chain,
                        input int brk_at);
        bit b[$];
        logic [7:0] m;
        m = d & 8'((1 << len) - 1);
        b.push_back(0);
        for (int i = 0; i < len; i++) b.push_back(m[i]);
        if (pe) b.push_back(par_of(m, pf, ps));
        if (ts) b.push_back(1);
        b.push_back(1);
        if (!chain) @(negedge clk);
        wr_stb = 1; wr_data = d; busy = 0; tx = 1; baud_end = 0; brk = 0;
        cfg_len = 2'(len - 5); cfg_par_en = pe; cfg_par_fix = pf;
        cfg_par_sel = ps; cfg_two_stop = ts;
        for (int k = 0; k < b.size(); k++) begin
            for (int c = 0; c < cpb; c++) begin
                @(negedge clk);
                wr_stb = 0; wr_data = ~d;
                cfg_len = ~cfg_len; cfg_par_en = ~pe; cfg_par_fix = ~pf;
                cfg_par_sel = ~ps; cfg_two_stop = ~ts;
                if (k == brk_at && c == 0) begin
                    brk = 1; tx = 0; busy = 1; baud_end = 0;
                    repeat (3) begin
                        @(negedge clk);
                        brk = 0; tx = 0; busy = 0; baud_end = 1;
                    end
                    return;
                end
                busy = !(k == busy_drop_at && c == 0);
                tx = b[k] ^ (k == flip_at);
                baud_end = (c == cpb - 1);
            end
        end
        @(negedge clk);
        baud_end = 0; tx = 1; busy = gap_busy; wr_stb = 0;
    endtask

    task automatic clean(input logic [7:0] d, input int len, input bit pe, input bit pf,
                         input bit ps, input bit ts, input int cpb);
        send(d, len, pe, pf, ps, ts, cpb, -1, -1, 0, 0, -1);
    endtask

    task automatic expect_err(input string req, input int code);
        idle(2);
        check({req, " flag"}, int'(err_flag), 1);
        check({req, " code"}, int'(err_code), code);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        int d0;
        rst = 1; brk = 0; wr_stb = 0; wr_data = 0; busy = 0; tx = 1; baud_end = 0;
        cfg_len = 0; cfg_par_en = 0; cfg_par_fix = 0; cfg_par_sel = 0; cfg_two_stop = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R10 reset flag", int'(err_flag), 0);
        check("R10 reset code", int'(err_code), 0);
        check("R11 reset done", int'(frame_done), 0);

        cur_req = "R3";
        d0 = done_cnt;
        clean(8'hA5, 8, 0, 0, 0, 0, 3); idle(3);
        check("R3 clean 8-bit frame", int'(err_flag), 0);
        check("R11 one done pulse", done_cnt - d0, 1);

        cur_req = "R4/R9";
        d0 = done_cnt;
        clean(8'hF3, 5, 0, 0, 0, 0, 2); idle(2);
        clean(8'h9A, 6, 0, 0, 0, 0, 2); idle(2);
        clean(8'h4E, 7, 0, 0, 0, 0, 2); idle(2);
        check("R4 lengths clean", int'(err_flag), 0);
        check("R4 three done pulses", done_cnt - d0, 3);

        cur_req = "R6";
        clean(8'h6B, 7, 1, 0, 0, 0, 2); idle(1);
        clean(8'h6B, 7, 1, 0, 1, 0, 2); idle(1);
        clean(8'h2C, 8, 1, 1, 0, 0, 2); idle(1);
        clean(8'h2C, 5, 1, 1, 1, 0, 2); idle(2);
        check("R6 parity kinds clean", int'(err_flag), 0);

        cur_req = "R5";
        clean(8'h81, 8, 0, 0, 0, 1, 2); idle(1);
        clean(8'h17, 6, 1, 0, 1, 1, 2); idle(2);
        check("R5 stop routing clean", int'(err_flag), 0);

        cur_req = "R1";
        d0 = done_cnt;
        clean(8'h55, 8, 0, 0, 0, 0, 2);
        send(8'hC3, 7, 1, 0, 0, 1, 2, -1, -1, 0, 1, -1); idle(2);
        check("R1 chained in gap", int'(err_flag), 0);
        check("R1 chained done pulses", done_cnt - d0, 2);

        cur_req = "R2";
        clean(8'hD2, 8, 0, 0, 0, 0, 1); idle(1);
        clean(8'h0F, 6, 1, 0, 1, 0, 6); idle(5);
        check("R2 interval lengths clean", int'(err_flag), 0);

        cur_req = "R1";
        d0 = done_cnt;
        @(negedge clk); wr_stb = 1; wr_data = 8'h00; busy = 1; tx = 1; cfg_len = 3;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); wr_stb = 0; busy = 1; tx = 1; baud_end = (i % 2 == 1);
        end
        idle(3);
        check("R1 write while busy ignored", int'(err_flag), 0);
        check("R1 no done after ignored write", done_cnt - d0, 0);

        cur_req = "R3"; do_reset();
        send(8'hA5, 8, 0, 0, 0, 0, 2, 0, -1, 0, 0, -1); expect_err("R3 start", 1);
        do_reset();
        send(8'hA5, 8, 0, 0, 0, 0, 2, 4, -1, 0, 0, -1); expect_err("R3 data", 2);
        cur_req = "R6"; do_reset();
        send(8'h6B, 7, 1, 0, 1, 0, 2, 8, -1, 0, 0, -1); expect_err("R6 parity", 3);
        cur_req = "R7"; do_reset();
        send(8'h3C, 8, 0, 0, 0, 1, 2, 9, -1, 0, 0, -1); expect_err("R7 stop", 4);
        cur_req = "R8"; do_reset();
        send(8'h3C, 8, 0, 0, 0, 0, 2, -1, 3, 0, 0, -1); expect_err("R8 busy low", 5);
        do_reset();
        send(8'h3C, 8, 0, 0, 0, 0, 2, -1, -1, 1, 0, -1); expect_err("R8 busy in gap", 6);
        cur_req = "R10"; do_reset();
        send(8'h3C, 6, 0, 0, 0, 0, 2, 0, 0, 0, 0, -1); expect_err("R10 priority", 1);
        do_reset();
        send(8'hFF, 8, 0, 0, 0, 0, 2, 2, -1, 0, 0, -1); idle(1);
        send(8'hFF, 8, 0, 0, 0, 0, 2, 9, -1, 0, 0, -1); expect_err("R10 sticky", 2);

        cur_req = "R12"; do_reset();
        d0 = done_cnt;
        send(8'h96, 8, 1, 0, 0, 0, 2, -1, -1, 0, 0, 4); idle(3);
        check("R12 break no error", int'(err_flag), 0);
        check("R12 break no done", done_cnt - d0, 0);
        clean(8'h96, 8, 1, 0, 0, 0, 2); idle(2);
        check("R12 frame after break", done_cnt - d0, 1);
        send(8'h96, 8, 0, 0, 0, 0, 2, 6, -1, 0, 0, -1); idle(1);
        send(8'h96, 8, 0, 0, 0, 0, 2, -1, -1, 0, 0, 3);
        expect_err("R12 break keeps error", 2);

        summary();
    end

endmodule